// File: doc/BRIEF.md
# Preloadable Interval Timer

This block is a 16-bit up-counting interval timer with a software preload value and a small register window. Software picks a period of N ticks by writing 0x10000 minus N as the preload. After a start command the count advances once on each cycle in which the prescaled tick enable input is high. When the count passes 0xFFFF it reloads from the preload register on that same tick, bumps a 4-bit overflow tally, and marks an interrupt as pending.

A timer control byte takes 3-bit command codes: 0 clears, 1 arms the timer without counting, 3 stops it and holds its state, and 7 starts it. The same byte returns the overflow tally in its upper nibble. An interrupt control byte holds an enable bit and a 3-bit request level. It shows the pending flag in bit 7, and writing a one to bit 7 acknowledges the interrupt. The tick source, and any vectoring or arbitration between several timers, belong to the surrounding logic.

Top module: `ivt_timer`

## Requirements
- R1: Writing code 0 to bits 2:0 of the timer control byte (offset 4) sets the count and the overflow tally to zero, and the count does not advance while that code is held.
- R2: With code 7 held, each cycle with `tick_en` high raises the count by one. With any other code held (1 arm, 3 stop and hold), the count and the tally keep their values.
- R3: A tick that finds the count at 0xFFFF loads the preload value (offset 0) into the count on that tick.
- R4: The timer control byte reads back as {tally[3:0], 1'b0, code[2:0]}. Each wrap adds one to the tally, and the tally stays at 15 once it reaches 15.
- R5: Interrupt control byte (offset 5): bit 3 is the enable and bits 2:0 are the level. `irq_req` is high exactly when an interrupt is pending and enabled, and `irq_level` carries the level while `irq_req` is high and reads 0 otherwise.
- R6: Bit 7 of the interrupt control byte reads 1 while an interrupt is pending. Writing 1 to bit 7 clears it, and writing 0 to bit 7 leaves it unchanged.
- R7: A wrap is flagged as pending whether or not the interrupt is enabled. If a wrap and an acknowledge write fall in the same cycle, the interrupt stays pending.
- R8: After reset the preload, count, timer control and interrupt control registers all read 0, and `irq_req` is low.
- R9: The register map is preload at offset 0, count at offset 2 (both halfword), timer control at offset 4 and interrupt control at offset 5 (both byte, in `bus_wdata[7:0]`/`bus_rdata[7:0]`). Other offsets read 0 and ignore writes. A count or timer control write in the same cycle as a tick takes priority and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaled count enable, one pulse per tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq_req | output | 1 | Interrupt request, pending and enabled |
| irq_level | output | 3 | Request level while `irq_req` is high |

## Verification
The assertions check on every cycle the relations that follow from one cycle of state:
- a step by one while running;
- holding while not running;
- reload on wrap, and zeroing on clear;
- the tally holding at its ceiling;
- the pending flag after a wrap or an acknowledge;
- the gating of `irq_req` and `irq_level`.

Only the bench scenarios show the multi-tick results:
- the count and tally after a full run of ticks for several preload and start values;
- tally saturation after twenty wraps;
- the read-back layout of both control bytes;
- the same-cycle race between an acknowledge and a wrap, seen at the ports.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int CNT_W   = 16;
  localparam int TALLY_W = 4;
  localparam int LVL_W   = 3;
  localparam int ADDR_W  = 3;
  localparam int CMD_W   = 3;

  localparam logic [ADDR_W-1:0] OFS_PRELOAD = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_COUNT   = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_TCTRL   = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_ICTRL   = 3'd5;

  localparam logic [CMD_W-1:0] CMD_CLEAR  = 3'd0;
  localparam logic [CMD_W-1:0] CMD_ARM    = 3'd1;
  localparam logic [CMD_W-1:0] CMD_STOP   = 3'd3;
  localparam logic [CMD_W-1:0] CMD_START  = 3'd7;

  localparam int ACK_BIT = 7;
  localparam int IEN_BIT = 3;
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int CNT_W   = ivt_pkg::CNT_W,
  parameter int TALLY_W = ivt_pkg::TALLY_W,
  parameter int LVL_W   = ivt_pkg::LVL_W
) (
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CNT_W-1:0]    preload_q,
  input  logic [CNT_W-1:0]    count_q,
  input  logic [CMD_W-1:0]    cmd_q,
  input  logic [TALLY_W-1:0]  tally_q,
  input  logic                pending_q,
  input  logic                ie_q,
  input  logic [LVL_W-1:0]    lvl_q,
  output logic                wr_preload,
  output logic                wr_count,
  output logic                wr_tctrl,
  output logic                wr_ictrl,
  output logic [CNT_W-1:0]    bus_rdata
);
  localparam int TCTRL_W = TALLY_W + 1 + CMD_W;
  localparam int ICTRL_W = 1 + 3 + 1 + LVL_W;

  logic [TCTRL_W-1:0] tctrl_view;
  logic [ICTRL_W-1:0] ictrl_view;

  assign wr_preload = bus_wr && (bus_addr == OFS_PRELOAD);
  assign wr_count   = bus_wr && (bus_addr == OFS_COUNT);
  assign wr_tctrl   = bus_wr && (bus_addr == OFS_TCTRL);
  assign wr_ictrl   = bus_wr && (bus_addr == OFS_ICTRL);

  assign tctrl_view = {tally_q, 1'b0, cmd_q};
  assign ictrl_view = {pending_q, 3'b000, ie_q, lvl_q};

  always_comb begin
    case (bus_addr)
      OFS_PRELOAD: bus_rdata = preload_q;
      OFS_COUNT:   bus_rdata = count_q;
      OFS_TCTRL:   bus_rdata = CNT_W'(tctrl_view);
      OFS_ICTRL:   bus_rdata = CNT_W'(ictrl_view);
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
  import ivt_pkg::*;
#(
  parameter int CNT_W   = ivt_pkg::CNT_W,
  parameter int TALLY_W = ivt_pkg::TALLY_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                wr_preload,
  input  logic                wr_count,
  input  logic                wr_tctrl,
  input  logic [CNT_W-1:0]    wdata,
  output logic [CNT_W-1:0]    preload_q,
  output logic [CNT_W-1:0]    count_q,
  output logic [CMD_W-1:0]    cmd_q,
  output logic [TALLY_W-1:0]  tally_q,
  output logic                advance_evt,
  output logic                wrap_evt
);
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] p);
    return (&c) ? p : c + 1'b1;
  endfunction

  function automatic logic [TALLY_W-1:0] bump_tally(input logic [TALLY_W-1:0] t);
    return (&t) ? t : t + 1'b1;
  endfunction

  logic running;
  logic clear_cmd;

  assign running     = (cmd_q == CMD_START);
  assign clear_cmd   = wr_tctrl && (wdata[CMD_W-1:0] == CMD_CLEAR);
  assign advance_evt = running && tick_en && !wr_count && !wr_tctrl;
  assign wrap_evt    = advance_evt && (&count_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preload_q <= '0;
      count_q   <= '0;
      cmd_q     <= CMD_CLEAR;
      tally_q   <= '0;
    end else begin
      if (wr_preload) preload_q <= wdata;
      if (wr_tctrl) begin
        cmd_q <= wdata[CMD_W-1:0];
        if (clear_cmd) begin
          count_q <= '0;
          tally_q <= '0;
        end
      end else if (wr_count) begin
        count_q <= wdata;
      end else if (advance_evt) begin
        count_q <= step_count(count_q, preload_q);
        if (wrap_evt) tally_q <= bump_tally(tally_q);
      end
    end
  end
endmodule

// File: rtl/ivt_irq.sv
module ivt_irq
  import ivt_pkg::*;
#(
  parameter int LVL_W = ivt_pkg::LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap_evt,
  input  logic              wr_ictrl,
  input  logic [7:0]        wbyte,
  output logic              pending_q,
  output logic              ie_q,
  output logic [LVL_W-1:0]  lvl_q,
  output logic              ack_evt,
  output logic              irq_req,
  output logic [LVL_W-1:0]  irq_level
);
  assign ack_evt = wr_ictrl && wbyte[ACK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      ie_q      <= 1'b0;
      lvl_q     <= '0;
    end else begin
      if (wr_ictrl) begin
        ie_q  <= wbyte[IEN_BIT];
        lvl_q <= wbyte[LVL_W-1:0];
      end
      if (wrap_evt)     pending_q <= 1'b1;
      else if (ack_evt) pending_q <= 1'b0;
    end
  end

  assign irq_req   = pending_q && ie_q;
  assign irq_level = irq_req ? lvl_q : '0;
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int CNT_W   = ivt_pkg::CNT_W,
  parameter int TALLY_W = ivt_pkg::TALLY_W,
  parameter int LVL_W   = ivt_pkg::LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               bus_wr,
  input  logic [2:0]         bus_addr,
  input  logic [15:0]        bus_wdata,
  output logic [15:0]        bus_rdata,
  output logic               irq_req,
  output logic [2:0]         irq_level
);
  logic               wr_preload, wr_count, wr_tctrl, wr_ictrl;
  logic [CNT_W-1:0]   preload_q, count_q;
  logic [CMD_W-1:0]   cmd_q;
  logic [TALLY_W-1:0] tally_q;
  logic               advance_evt, wrap_evt, ack_evt;
  logic               pending_q, ie_q;
  logic [LVL_W-1:0]   lvl_q;

  ivt_regs #(.CNT_W(CNT_W), .TALLY_W(TALLY_W), .LVL_W(LVL_W)) u_regs (
    .bus_wr(bus_wr), .bus_addr(bus_addr),
    .preload_q(preload_q), .count_q(count_q), .cmd_q(cmd_q), .tally_q(tally_q),
    .pending_q(pending_q), .ie_q(ie_q), .lvl_q(lvl_q),
    .wr_preload(wr_preload), .wr_count(wr_count), .wr_tctrl(wr_tctrl),
    .wr_ictrl(wr_ictrl), .bus_rdata(bus_rdata)
  );

  ivt_counter #(.CNT_W(CNT_W), .TALLY_W(TALLY_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .wr_preload(wr_preload), .wr_count(wr_count), .wr_tctrl(wr_tctrl),
    .wdata(bus_wdata),
    .preload_q(preload_q), .count_q(count_q), .cmd_q(cmd_q), .tally_q(tally_q),
    .advance_evt(advance_evt), .wrap_evt(wrap_evt)
  );

  ivt_irq #(.LVL_W(LVL_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .wrap_evt(wrap_evt),
    .wr_ictrl(wr_ictrl), .wbyte(bus_wdata[7:0]),
    .pending_q(pending_q), .ie_q(ie_q), .lvl_q(lvl_q), .ack_evt(ack_evt),
    .irq_req(irq_req), .irq_level(irq_level)
  );
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
  parameter int CNT_W   = 16,
  parameter int TALLY_W = 4,
  parameter int LVL_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_en,
  input logic               wr_count,
  input logic               wr_tctrl,
  input logic [2:0]         wcode,
  input logic [CNT_W-1:0]   preload_q,
  input logic [CNT_W-1:0]   count_q,
  input logic [2:0]         cmd_q,
  input logic [TALLY_W-1:0] tally_q,
  input logic               wrap_evt,
  input logic               ack_evt,
  input logic               pending_q,
  input logic               ie_q,
  input logic               irq_req,
  input logic [LVL_W-1:0]   irq_level
);
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tctrl && wcode == 3'd0) |=> (count_q == '0 && tally_q == '0)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != 3'd7 && !wr_count && !wr_tctrl) |=> ($stable(count_q) && $stable(tally_q))); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == 3'd7 && tick_en && !wr_count && !wr_tctrl && !(&count_q))
      |=> count_q == CNT_W'($past(count_q) + 1'b1)); // R2
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> count_q == $past(preload_q)); // R3
  AST_TALLY_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && (&tally_q)) |=> (&tally_q)); // R4
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pending_q && ie_q)); // R5
  AST_LEVEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_level == '0); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && !wrap_evt) |=> !pending_q); // R6
  AST_WRAP_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> pending_q); // R7
endmodule

bind ivt_timer ivt_checker #(.CNT_W(CNT_W), .TALLY_W(TALLY_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
  .wr_count(wr_count), .wr_tctrl(wr_tctrl), .wcode(bus_wdata[2:0]),
  .preload_q(preload_q), .count_q(count_q), .cmd_q(cmd_q), .tally_q(tally_q),
  .wrap_evt(wrap_evt), .ack_evt(ack_evt), .pending_q(pending_q), .ie_q(ie_q),
  .irq_req(irq_req), .irq_level(irq_level)
);

// File: tb/ivt_timer_tb.sv
module ivt_timer_tb;
  localparam logic [2:0] A_PRE = 3'd0, A_CNT = 3'd2, A_TCTL = 3'd4, A_ICTL = 3'd5;

  typedef struct packed {
    logic [15:0] pre;
    logic [15:0] start;
    logic [7:0]  ticks;
    logic [15:0] exp_cnt;
    logic [3:0]  exp_tally;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{16'hFFF0, 16'hFFF0, 8'd5,  16'hFFF5, 4'd0},
    '{16'hFFF0, 16'hFFFE, 8'd1,  16'hFFFF, 4'd0},
    '{16'hFFF0, 16'hFFFF, 8'd1,  16'hFFF0, 4'd1},
    '{16'hFFF0, 16'hFFFE, 8'd2,  16'hFFF0, 4'd1},
    '{16'hFFFC, 16'hFFFC, 8'd8,  16'hFFFC, 4'd2},
    '{16'hFFFE, 16'hFFFE, 8'd40, 16'hFFFE, 4'd15},
    '{16'h0000, 16'hFFFF, 8'd3,  16'h0002, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq_req;
  logic [2:0] irq_level;

  int checks = 0;
  int failures = 0;
  logic [15:0] rv;

  always #5 clk = ~clk;

  ivt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_level(irq_level)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic tk = 1'b0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = tk;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset values
    rd(A_PRE, rv);  chk("R8 preload", rv, 16'h0000);
    rd(A_CNT, rv);  chk("R8 count", rv, 16'h0000);
    rd(A_TCTL, rv); chk("R8 tctrl", rv, 16'h0000);
    rd(A_ICTL, rv); chk("R8 ictrl", rv, 16'h0000);
    chk("R8 irq_req", {15'd0, irq_req}, 16'h0000);

    // R2 R3 R4: table of runs
    foreach (VECS[k]) begin
      wr(A_TCTL, 16'h0000);
      wr(A_PRE, VECS[k].pre);
      wr(A_CNT, VECS[k].start);
      wr(A_TCTL, 16'h0007);
      ticks(int'(VECS[k].ticks));
      wr(A_TCTL, 16'h0003);
      rd(A_CNT, rv);  chk("R3 table count", rv, VECS[k].exp_cnt);
      rd(A_TCTL, rv); chk("R4 table tctrl", rv, {8'h00, VECS[k].exp_tally, 4'h3});
    end
    wr(A_ICTL, 16'h0080);

    // R2: stop and arm hold the count
    wr(A_TCTL, 16'h0000);
    wr(A_CNT, 16'h0100);
    wr(A_TCTL, 16'h0007);
    ticks(3);
    rd(A_CNT, rv); chk("R2 run", rv, 16'h0103);
    wr(A_TCTL, 16'h0003);
    ticks(5);
    rd(A_CNT, rv);  chk("R2 stop holds", rv, 16'h0103);
    rd(A_TCTL, rv); chk("R4 stop code", rv, 16'h0003);
    wr(A_TCTL, 16'h0001);
    ticks(4);
    rd(A_CNT, rv);  chk("R2 arm holds", rv, 16'h0103);
    rd(A_TCTL, rv); chk("R4 arm code", rv, 16'h0001);
    wr(A_TCTL, 16'h0007);
    ticks(1);
    rd(A_CNT, rv); chk("R2 resume", rv, 16'h0104);

    // R1: clear zeroes count and tally, ticks ignored while cleared
    wr(A_CNT, 16'hFFFF);
    ticks(1);
    rd(A_TCTL, rv); chk("R4 tally one", rv, 16'h0017);
    wr(A_TCTL, 16'h0000);
    ticks(3);
    rd(A_CNT, rv);  chk("R1 count zero", rv, 16'h0000);
    rd(A_TCTL, rv); chk("R1 tally zero", rv, 16'h0000);
    wr(A_ICTL, 16'h0080);

    // R5 R6: enabled interrupt
    wr(A_ICTL, 16'h000D);
    wr(A_PRE, 16'hFFF0);
    wr(A_CNT, 16'hFFFF);
    wr(A_TCTL, 16'h0007);
    ticks(1);
    rd(A_CNT, rv);  chk("R3 reload", rv, 16'hFFF0);
    rd(A_ICTL, rv); chk("R6 pending read", rv, 16'h008D);
    chk("R5 irq_req", {15'd0, irq_req}, 16'h0001);
    chk("R5 irq_level", {13'd0, irq_level}, 16'h0005);
    wr(A_ICTL, 16'h000D);
    rd(A_ICTL, rv); chk("R6 zero write keeps", rv, 16'h008D);
    wr(A_ICTL, 16'h008D);
    rd(A_ICTL, rv); chk("R6 ack clears", rv, 16'h000D);
    chk("R5 irq_req low", {15'd0, irq_req}, 16'h0000);
    chk("R5 level idle", {13'd0, irq_level}, 16'h0000);

    // R7: disabled interrupt still pends
    wr(A_ICTL, 16'h0005);
    wr(A_CNT, 16'hFFFF);
    ticks(1);
    rd(A_ICTL, rv); chk("R7 pend disabled", rv, 16'h0085);
    chk("R5 gated", {15'd0, irq_req}, 16'h0000);

    // R7: ack and wrap in the same cycle
    wr(A_ICTL, 16'h000A);
    wr(A_CNT, 16'hFFFF);
    wr(A_ICTL, 16'h008A, 1'b1);
    rd(A_ICTL, rv); chk("R7 race pending", rv, 16'h008A);
    chk("R7 race irq_req", {15'd0, irq_req}, 16'h0001);
    wr(A_ICTL, 16'h008A);
    rd(A_ICTL, rv); chk("R6 ack after race", rv, 16'h000A);

    // R9: write priority and unmapped offsets
    wr(A_CNT, 16'h5555, 1'b1);
    rd(A_CNT, rv); chk("R9 write beats tick", rv, 16'h5555);
    wr(A_TCTL, 16'h0007, 1'b1);
    rd(A_CNT, rv); chk("R9 ctrl write drops tick", rv, 16'h5555);
    wr(3'd1, 16'hABCD);
    rd(A_PRE, rv); chk("R9 odd offset ignored", rv, 16'hFFF0);
    rd(3'd6, rv);  chk("R9 unmapped reads zero", rv, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule